// File: doc/BRIEF.md
# Multi-mode effective address generator

This block turns one operand specifier into a memory effective address. Each request carries a 3-bit mode code and a 2-bit operand-size code. It also carries the contents of a base register and an index register, a signed 16-bit displacement, an absolute address field, the program counter and the length of the current instruction. The block registers the result: the address, a flag that says whether the operand lives in memory at all, and, for the two auto-modify modes, a write-back value for the base register with an enable.

The block has no register file, no memory port and no instruction fetch. The surrounding pipeline reads the registers and presents their values with the request. It then uses the registered address for the memory access and, when the write-back enable is set, writes the write-back value into the base register. Operand size steps the auto-modify modes and scales the index. Every sum wraps modulo 2^32.

Top module: `ea_gen`

## Requirements
- R1: While reset is held, and after it is released until the first request, `vld_o`, `mem_o` and `wb_en_o` are low.
- R2: A request with `req_i` high at a rising edge produces its result on the outputs right after that edge, with `vld_o` high. After an edge with `req_i` low, `vld_o` is low.
- R3: Mode 0 marks a non-memory operand (register or immediate). It gives `mem_o`=0 and `ea_o`=0. Every mode from 1 to 7 gives `mem_o`=1.
- R4: Mode 1 (absolute) gives `ea_o` = `abs_i`.
- R5: Mode 2 (register indirect) gives `ea_o` = `base_i`.
- R6: Mode 3 (post-increment) gives `ea_o` = `base_i` and `wb_val_o` = `base_i` + operand size.
- R7: Mode 4 (pre-decrement) gives `ea_o` = `base_i` − operand size and `wb_val_o` equal to that same value.
- R8: Mode 5 (base plus displacement) gives `ea_o` = `base_i` + sign-extended `disp_i`. A zero displacement gives `base_i`.
- R9: Mode 6 (scaled index) gives `ea_o` = `base_i` + (`index_i` << scale), where the scale is 0, 1 or 2 for sizes of 1, 2 or 4 bytes.
- R10: Mode 7 (PC-relative) gives `ea_o` = `pc_i` + `len_i` + sign-extended `disp_i`.
- R11: Size code 00 means 1 byte, 01 means 2 bytes, 10 means 4 bytes. Code 11 is treated as 4 bytes.
- R12: `wb_en_o` is high only for modes 3 and 4. In every other mode `wb_val_o` is 0.
- R13: All address arithmetic wraps modulo 2^32. For example, a 4-byte pre-decrement from 0 gives 0xFFFFFFFC, and a 4-byte post-increment from 0xFFFFFFFC writes back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request strobe and load enable |
| mode_i | input | 3 | Addressing mode code |
| size_i | input | 2 | Operand size code |
| base_i | input | 32 | Base register contents |
| index_i | input | 32 | Index register contents |
| disp_i | input | 16 | Signed displacement or offset |
| abs_i | input | 32 | Absolute address field |
| pc_i | input | 32 | Address of the current instruction |
| len_i | input | 4 | Length of the current instruction in bytes |
| vld_o | output | 1 | Result valid |
| mem_o | output | 1 | Operand is in memory |
| ea_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_val_o | output | 32 | Base register write-back value |

## Verification
The hardest cases to reach are the carries out of bit 31: an auto-modify step that crosses zero, or a negative displacement added to a small base. Random register values almost never land on these. The stimulus therefore places base values at 0 and 0xFFFFFFFC on purpose for the 4-byte auto-modify modes. It pairs a small program counter with a negative offset, and it uses the reserved size code to confirm that it falls back to a step of 4. Requests arrive both back to back and with idle gaps, so the bench can confirm that `vld_o` drops in a gap while the held address does not matter.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    EA_NOMEM   = 3'd0,
    EA_ABS     = 3'd1,
    EA_IND     = 3'd2,
    EA_POSTINC = 3'd3,
    EA_PREDEC  = 3'd4,
    EA_DISP    = 3'd5,
    EA_INDEX   = 3'd6,
    EA_PCREL   = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } ea_size_e;
endpackage

// File: rtl/ea_size_dec.sv
module ea_size_dec #(
  parameter int AW = 32
) (
  input  logic [1:0]    size_i,
  output logic [AW-1:0] step_o,
  output logic [1:0]    shamt_o
);
  import ea_pkg::*;

  always_comb begin
    unique case (ea_size_e'(size_i))
      SZ_BYTE: shamt_o = 2'd0;
      SZ_HALF: shamt_o = 2'd1;
      default: shamt_o = 2'd2;
    endcase
    step_o = {{(AW-1){1'b0}}, 1'b1} << shamt_o;
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] step_i,
  input  logic [1:0]    shamt_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] abs_i,
  input  logic [AW-1:0] pc_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] ea_o,
  output logic          mem_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o
);
  import ea_pkg::*;

  localparam int EXTW = AW - DW;
  localparam int PADW = AW - LW;

  logic [AW-1:0] disp_sx;
  logic [AW-1:0] len_zx;
  logic [AW-1:0] next_pc;
  logic [AW-1:0] scaled;
  logic [AW-1:0] dec_base;

  assign disp_sx  = {{EXTW{disp_i[DW-1]}}, disp_i};
  assign len_zx   = {{PADW{1'b0}}, len_i};
  assign next_pc  = pc_i + len_zx;
  assign scaled   = index_i << shamt_i;
  assign dec_base = base_i - step_i;

  always_comb begin
    ea_o     = '0;
    mem_o    = 1'b1;
    wb_en_o  = 1'b0;
    wb_val_o = '0;
    unique case (ea_mode_e'(mode_i))
      EA_NOMEM:   mem_o = 1'b0;
      EA_ABS:     ea_o  = abs_i;
      EA_IND:     ea_o  = base_i;
      EA_POSTINC: begin
        ea_o     = base_i;
        wb_en_o  = 1'b1;
        wb_val_o = base_i + step_i;
      end
      EA_PREDEC: begin
        ea_o     = dec_base;
        wb_en_o  = 1'b1;
        wb_val_o = dec_base;
      end
      EA_DISP:    ea_o = base_i + disp_sx;
      EA_INDEX:   ea_o = base_i + scaled;
      default:    ea_o = next_pc + disp_sx;
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [2:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [31:0]   base_i,
  input  logic [31:0]   index_i,
  input  logic [15:0]   disp_i,
  input  logic [31:0]   abs_i,
  input  logic [31:0]   pc_i,
  input  logic [3:0]    len_i,
  output logic          vld_o,
  output logic          mem_o,
  output logic [31:0]   ea_o,
  output logic          wb_en_o,
  output logic [31:0]   wb_val_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [AW-1:0] step;
  logic [1:0]    shamt;
  logic [AW-1:0] c_ea, c_wbv;
  logic          c_mem, c_wb;

  ea_size_dec #(.AW(AW)) u_size (
    .size_i (size_i),
    .step_o (step),
    .shamt_o(shamt)
  );

  ea_calc #(.AW(AW), .DW(DW), .LW(LW)) u_calc (
    .mode_i  (mode_i),
    .step_i  (step),
    .shamt_i (shamt),
    .base_i  (base_i),
    .index_i (index_i),
    .disp_i  (disp_i),
    .abs_i   (abs_i),
    .pc_i    (pc_i),
    .len_i   (len_i),
    .ea_o    (c_ea),
    .mem_o   (c_mem),
    .wb_en_o (c_wb),
    .wb_val_o(c_wbv)
  );

  logic          vld_q, vld_d;
  logic          mem_q, mem_d;
  logic          wb_q, wb_d;
  logic [AW-1:0] ea_q, ea_d;
  logic [AW-1:0] wbv_q, wbv_d;

  always_comb begin
    vld_d = req_i;
    mem_d = mem_q;
    wb_d  = 1'b0;
    ea_d  = ea_q;
    wbv_d = wbv_q;
    if (req_i) begin
      mem_d = c_mem;
      wb_d  = c_wb;
      ea_d  = c_ea;
      wbv_d = c_wbv;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      mem_q <= 1'b0;
      wb_q  <= 1'b0;
      ea_q  <= '0;
      wbv_q <= '0;
    end else begin
      vld_q <= vld_d;
      mem_q <= mem_d;
      wb_q  <= wb_d;
      ea_q  <= ea_d;
      wbv_q <= wbv_d;
    end
  end

  assign vld_o    = vld_q;
  assign mem_o    = mem_q;
  assign wb_en_o  = wb_q;
  assign ea_o     = ea_q;
  assign wb_val_o = wbv_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic [2:0]  mode_i,
  input logic [1:0]  size_i,
  input logic [31:0] base_i,
  input logic [15:0] disp_i,
  input logic [31:0] pc_i,
  input logic [3:0]  len_i,
  input logic        vld_o,
  input logic        mem_o,
  input logic [31:0] ea_o,
  input logic        wb_en_o,
  input logic [31:0] wb_val_o
);
  function automatic logic [31:0] bytes_of(input logic [1:0] c);
    return (c == 2'd0) ? 32'd1 : (c == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  p_gap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_i) |-> !vld_o);

  p_nomem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(mode_i) == 3'd0) |-> (!mem_o && ea_o == 32'd0));

  p_postinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(mode_i) == 3'd3) |->
      (ea_o == $past(base_i) && wb_val_o == $past(base_i) + bytes_of($past(size_i))));

  p_predec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(mode_i) == 3'd4) |->
      (ea_o == $past(base_i) - bytes_of($past(size_i)) && wb_val_o == ea_o));

  p_pcrel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(mode_i) == 3'd7) |->
      (ea_o == $past(pc_i) + {28'd0, $past(len_i)} + {{16{$past(disp_i[15])}}, $past(disp_i)}));

  p_wb_modes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (vld_o && ($past(mode_i) == 3'd3 || $past(mode_i) == 3'd4)));
endmodule

bind ea_gen ea_gen_chk u_ea_gen_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .mode_i  (mode_i),
  .size_i  (size_i),
  .base_i  (base_i),
  .disp_i  (disp_i),
  .pc_i    (pc_i),
  .len_i   (len_i),
  .vld_o   (vld_o),
  .mem_o   (mem_o),
  .ea_o    (ea_o),
  .wb_en_o (wb_en_o),
  .wb_val_o(wb_val_o)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [31:0] base = '0, index = '0, absf = '0, pc = '0;
  logic [15:0] disp = '0;
  logic [3:0]  len = '0;
  logic        vld, mem, wb;
  logic [31:0] ea, wbv;

  int total = 0;
  int bad = 0;
  logic req_seen = 1'b0;
  logic mon_on = 1'b0;

  logic [31:0] q_ea[$];
  logic [31:0] q_wbv[$];
  logic        q_mem[$];
  logic        q_wb[$];
  string       q_tag[$];

  ea_gen i_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .size_i(size),
    .base_i(base), .index_i(index), .disp_i(disp), .abs_i(absf), .pc_i(pc),
    .len_i(len), .vld_o(vld), .mem_o(mem), .ea_o(ea), .wb_en_o(wb), .wb_val_o(wbv)
  );

  always #4 clk = ~clk;
  always @(posedge clk) req_seen <= req;

  task automatic send(input logic [2:0] m, input logic [1:0] sz, input logic [31:0] b,
                      input logic [31:0] ix, input logic [15:0] d, input logic [31:0] ab,
                      input logic [31:0] p, input logic [3:0] ln, input string tag);
    logic [31:0] s, e, w, dsx;
    logic        mm, we;
    int          sh;
    sh  = (sz == 2'd0) ? 0 : (sz == 2'd1) ? 1 : 2;
    s   = 32'd1 << sh;
    dsx = {{16{d[15]}}, d};
    e = 32'd0; w = 32'd0; mm = 1'b1; we = 1'b0;
    case (m)
      3'd0: mm = 1'b0;
      3'd1: e = ab;
      3'd2: e = b;
      3'd3: begin e = b; we = 1'b1; w = b + s; end
      3'd4: begin e = b - s; we = 1'b1; w = b - s; end
      3'd5: e = b + dsx;
      3'd6: e = b + (ix << sh);
      default: e = p + {28'd0, ln} + dsx;
    endcase
    q_ea.push_back(e); q_wbv.push_back(w); q_mem.push_back(mm);
    q_wb.push_back(we); q_tag.push_back(tag);
    req = 1'b1; mode = m; size = sz; base = b; index = ix; disp = d;
    absf = ab; pc = p; len = ln;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req = 1'b0;
    base = 32'hDEAD_BEEF;
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (mon_on) begin
        total++;
        if (vld !== req_seen) begin
          bad++;
          $display("FAIL R2: vld=%b expected %b", vld, req_seen);
        end
        if (vld === 1'b1) begin
          if (q_ea.size() == 0) begin
            bad++;
            $display("FAIL R2: unexpected result ea=%h expected none", ea);
          end else begin
            logic [31:0] xe, xw;
            logic xm, xb;
            string t;
            xe = q_ea.pop_front(); xw = q_wbv.pop_front();
            xm = q_mem.pop_front(); xb = q_wb.pop_front(); t = q_tag.pop_front();
            total++;
            if (ea !== xe || wbv !== xw || mem !== xm || wb !== xb) begin
              bad++;
              $display("FAIL %s: ea=%h mem=%b wb=%b wbv=%h expected ea=%h mem=%b wb=%b wbv=%h",
                       t, ea, mem, wb, wbv, xe, xm, xb, xw);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (vld !== 1'b0 || mem !== 1'b0 || wb !== 1'b0) begin
      bad++;
      $display("FAIL R1: in reset vld=%b mem=%b wb=%b expected 0 0 0", vld, mem, wb);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (vld !== 1'b0 || mem !== 1'b0 || wb !== 1'b0) begin
      bad++;
      $display("FAIL R1: after release vld=%b mem=%b wb=%b expected 0 0 0", vld, mem, wb);
    end
    mon_on = 1'b1;

    send(3'd0, 2'd2, 32'h1111_2222, 32'h3, 16'h44, 32'h55, 32'h66, 4'd2, "R3 nomem");
    send(3'd1, 2'd0, 32'h0, 32'h0, 16'h0, 32'h1234_5678, 32'h0, 4'd4, "R4 absolute");
    send(3'd2, 2'd1, 32'hCAFE_0000, 32'h9, 16'h7, 32'h0, 32'h0, 4'd4, "R5 indirect");
    idle(2);
    send(3'd3, 2'd0, 32'h0000_0100, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R6 postinc byte");
    send(3'd3, 2'd1, 32'h0000_0100, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R6 postinc half");
    send(3'd3, 2'd2, 32'hFFFF_FFFC, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R13 postinc wrap");
    send(3'd3, 2'd3, 32'h0000_2000, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R11 reserved size");
    send(3'd4, 2'd2, 32'h0000_0000, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R13 predec wrap");
    send(3'd4, 2'd0, 32'h0000_0010, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R7 predec byte");
    send(3'd4, 2'd1, 32'h0000_0010, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R7 predec half");
    idle(1);
    send(3'd5, 2'd2, 32'h0001_0000, 32'h0, 16'h7FFF, 32'h0, 32'h0, 4'd2, "R8 disp positive");
    send(3'd5, 2'd2, 32'h0001_0000, 32'h0, 16'hFFFF, 32'h0, 32'h0, 4'd2, "R8 disp negative");
    send(3'd5, 2'd2, 32'h0000_0004, 32'h0, 16'h8000, 32'h0, 32'h0, 4'd2, "R13 disp wrap");
    send(3'd5, 2'd0, 32'hABCD_0123, 32'h0, 16'h0000, 32'h0, 32'h0, 4'd2, "R8 zero disp");
    send(3'd6, 2'd0, 32'h0000_1000, 32'h5, 16'h0, 32'h0, 32'h0, 4'd2, "R9 index x1");
    send(3'd6, 2'd1, 32'h0000_1000, 32'h5, 16'h0, 32'h0, 32'h0, 4'd2, "R9 index x2");
    send(3'd6, 2'd2, 32'h0000_1000, 32'h5, 16'h0, 32'h0, 32'h0, 4'd2, "R9 index x4");
    send(3'd6, 2'd3, 32'h0000_1000, 32'h5, 16'h0, 32'h0, 32'h0, 4'd2, "R11 index reserved");
    idle(3);
    send(3'd7, 2'd2, 32'h0, 32'h0, 16'hFFF0, 32'h0, 32'h0000_1000, 4'd4, "R10 pcrel back");
    send(3'd7, 2'd0, 32'h0, 32'h0, 16'h0020, 32'h0, 32'h0000_2000, 4'd6, "R10 pcrel fwd");
    send(3'd7, 2'd1, 32'h0, 32'h0, 16'hFFFE, 32'h0, 32'h0000_0000, 4'd1, "R13 pcrel wrap");
    send(3'd2, 2'd2, 32'h0000_0040, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R12 no wb indirect");
    send(3'd0, 2'd2, 32'h0000_0040, 32'h0, 16'h0, 32'h0, 32'h0, 4'd2, "R12 no wb nomem");
    idle(4);

    total++;
    if (q_ea.size() != 0) begin
      bad++;
      $display("FAIL R2: %0d results missing, expected 0", q_ea.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule